// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This unit gives an 8-bit CPU with a 16-bit internal address bus one hardware breakpoint. Software loads a 16-bit target into two byte-wide registers and turns on an enable bit. Two byte comparators then watch the CPU address bus. When both bytes agree while the unit is enabled, the unit latches a match flag and raises a break request. The request lands on an instruction boundary.

A match that arrives partway through an instruction is held as pending until the CPU reports the final cycle of that instruction. A match that arrives on the final cycle takes effect at once. While the request is up, the unit tells the CPU to load the software-interrupt opcode and presents the vector address to fetch. This vector is the monitor vector when monitor mode is active and the normal vector otherwise. The request stays up until the CPU acknowledges it. Each match event produces only one request.

A status register also carries a wait bit. The unit sets it when a break is taken while the CPU is in its wait state, and software clears it by writing zero. The register bus is a plain byte interface. Writes take effect on the clock edge and reads are combinational with no side effects.

Top module: `brk_unit`

## Requirements
- R1: After reset, the status register (0xFE00) reads 0x10, and the control (0xFE0B), target high (0xFE09), target low (0xFE0A), auxiliary (0xFE02) and flag-control (0xFE03) registers read 0x00. No request is raised.
- R2: The register at 0xFE09 holds target bits 15..8 and the one at 0xFE0A holds bits 7..0. Both are fully readable and writable.
- R3: Only bit 0 of 0xFE02 and bit 7 of 0xFE03 are storage. Every other bit of those registers, and any unmapped offset, reads 0 and ignores writes.
- R4: A break needs both address bytes to equal the target while enable (0xFE0B bit 7) is 1. A mismatch in either byte, or enable at 0, raises neither the flag nor a request.
- R5: Match flag (0xFE0B bit 6) reads 1 from the cycle after a match event. Writing 0 to it clears it, writing 1 has no effect, and clearing enable also clears it.
- R6: A match on a cycle where the instruction-last input is low raises the request only in the cycle after the next cycle on which instruction-last is high.
- R7: A match on a cycle where instruction-last is high raises the request in the next cycle.
- R8: While the request is high, the force output is 1 and the opcode output is 0x83. The vector output is 0xFFFC when monitor mode is low and 0xFEFC when monitor mode is high. While the request is low, force and opcode are 0.
- R9: The request stays high until acknowledged and is low the cycle after the acknowledge. An address that keeps matching after that raises no second request.
- R10: Status bit 1 is set when a break is taken while the CPU wait input is high. Writing 0 to it clears it and writing 1 has no effect, so the register reads 0x12 while the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 16 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cpu_addr_i | input | 16 | CPU internal address bus |
| instr_last_i | input | 1 | High on the final cycle of the current instruction |
| monitor_i | input | 1 | Monitor mode active |
| cpu_wait_i | input | 1 | CPU is in its wait state |
| brk_ack_i | input | 1 | CPU acknowledges the break request |
| brk_req_o | output | 1 | Break interrupt request |
| force_op_o | output | 1 | Force the software-interrupt opcode into the instruction register |
| opcode_o | output | 8 | Opcode to force (0x83 while forcing) |
| vector_o | output | 16 | Vector address for the program counter |

## Verification
The bench drives a match on a middle cycle of a multi-cycle instruction and checks that the request waits for the boundary. A design that broke at once there would abandon an instruction halfway. It also drives a match on the final cycle, where a design that always deferred would overshoot by a whole instruction. A match held across the acknowledge is included; a level-triggered design would re-break in a loop. Further cases cover a disabled unit, a one-byte mismatch, monitor mode and the write-zero-to-clear bits, where a design that set bits on writing 1 or ignored the enable would show at the ports.

// File: rtl/brk_pkg.sv
// Package: shared constants and types for the address-match breakpoint unit.
// Assumes a 16-bit register bus address and byte-wide register data.
package brk_pkg;
    localparam int ADDR_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = ADDR_W / BYTE_W;
    localparam int REG_AW  = 16;

    localparam logic [REG_AW-1:0] OFS_STAT   = 16'hFE00;
    localparam logic [REG_AW-1:0] OFS_AUX    = 16'hFE02;
    localparam logic [REG_AW-1:0] OFS_FCTL   = 16'hFE03;
    localparam logic [REG_AW-1:0] OFS_TGT_HI = 16'hFE09;
    localparam logic [REG_AW-1:0] OFS_TGT_LO = 16'hFE0A;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 16'hFE0B;

    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_FLAG_BIT = 6;
    localparam int STAT_WAIT_BIT = 1;
    localparam int FCTL_BIT      = 7;
    localparam int AUX_BIT       = 0;
    localparam logic [BYTE_W-1:0] STAT_FIXED = 8'h10;

    localparam logic [BYTE_W-1:0] SWI_OP   = 8'h83;
    localparam logic [ADDR_W-1:0] VEC_USER = 16'hFFFC;
    localparam logic [ADDR_W-1:0] VEC_MON  = 16'hFEFC;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PEND = 2'd1,
        SEQ_TAKE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/brk_regfile.sv
// Module: register file of the breakpoint unit.
// Holds target bytes, enable, match flag, wait bit and two spare control bits.
// Assumes writes occur on reg_wr at the clock edge; reads are combinational.
module brk_regfile
    import brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              hit_event,
    input  logic              wait_set,
    output logic [ADDR_W-1:0] target,
    output logic              en
);
    logic [BYTE_W-1:0] tgt_hi_q, tgt_lo_q;
    logic              en_q, flag_q, wait_q, fctl_q, aux_q;
    logic              wr_stat, wr_aux, wr_fctl, wr_hi, wr_lo, wr_ctrl;

    // Decode write strobes per register.
    always_comb begin
        wr_stat = reg_wr && (reg_addr == OFS_STAT);
        wr_aux  = reg_wr && (reg_addr == OFS_AUX);
        wr_fctl = reg_wr && (reg_addr == OFS_FCTL);
        wr_hi   = reg_wr && (reg_addr == OFS_TGT_HI);
        wr_lo   = reg_wr && (reg_addr == OFS_TGT_LO);
        wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    end

    // Target address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_hi_q <= '0;
            tgt_lo_q <= '0;
        end else begin
            if (wr_hi) tgt_hi_q <= reg_wdata;
            if (wr_lo) tgt_lo_q <= reg_wdata;
        end
    end

    // Enable and match flag; clearing enable wins, then a hit, then a write of 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) en_q <= reg_wdata[CTRL_EN_BIT];
            if (wr_ctrl && !reg_wdata[CTRL_EN_BIT])       flag_q <= 1'b0;
            else if (hit_event)                           flag_q <= 1'b1;
            else if (wr_ctrl && !reg_wdata[CTRL_FLAG_BIT]) flag_q <= 1'b0;
        end
    end

    // Wait status bit: set by a break taken in wait, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    wait_q <= 1'b0;
        else if (wait_set)                             wait_q <= 1'b1;
        else if (wr_stat && !reg_wdata[STAT_WAIT_BIT]) wait_q <= 1'b0;
    end

    // Spare single-bit control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fctl_q <= 1'b0;
            aux_q  <= 1'b0;
        end else begin
            if (wr_fctl) fctl_q <= reg_wdata[FCTL_BIT];
            if (wr_aux)  aux_q  <= reg_wdata[AUX_BIT];
        end
    end

    // Read multiplexer; unimplemented bits and offsets return 0.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_STAT: begin
                reg_rdata = STAT_FIXED;
                reg_rdata[STAT_WAIT_BIT] = wait_q;
            end
            OFS_AUX:    reg_rdata[AUX_BIT]  = aux_q;
            OFS_FCTL:   reg_rdata[FCTL_BIT] = fctl_q;
            OFS_TGT_HI: reg_rdata = tgt_hi_q;
            OFS_TGT_LO: reg_rdata = tgt_lo_q;
            OFS_CTRL: begin
                reg_rdata[CTRL_EN_BIT]   = en_q;
                reg_rdata[CTRL_FLAG_BIT] = flag_q;
            end
            default:    reg_rdata = '0;
        endcase
    end

    assign target = {tgt_hi_q, tgt_lo_q};
    assign en     = en_q;
endmodule

// File: rtl/brk_match.sv
// Module: byte-sliced address comparator.
// One equality comparator per address byte; a hit needs all bytes equal and enable set.
module brk_match
    import brk_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] target,
    input  logic              en,
    output logic              hit
);
    logic [NBYTES-1:0] byte_eq;

    // One comparator per byte lane.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign byte_eq[b] = (bus_addr[b*BYTE_W +: BYTE_W] == target[b*BYTE_W +: BYTE_W]);
    end

    assign hit = en && (&byte_eq);
endmodule

// File: rtl/brk_sequencer.sv
// Module: break request sequencer.
// Turns match events into one request aligned to an instruction boundary.
// Assumes instr_last marks the final cycle of every instruction and ack is a one-cycle pulse.
module brk_sequencer
    import brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hit,
    input  logic instr_last,
    input  logic ack,
    input  logic cpu_wait,
    output logic hit_event,
    output logic wait_set,
    output logic req
);
    seq_state_t state_q, state_d;
    logic       hit_prev_q;

    // Remember the previous hit so a held match counts once.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_prev_q <= 1'b0;
        else        hit_prev_q <= hit;
    end

    assign hit_event = hit && !hit_prev_q;

    // Next-state logic: defer to boundary, take at once on the final cycle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (hit_event) state_d = instr_last ? SEQ_TAKE : SEQ_PEND;
            SEQ_PEND: begin
                if (!en)             state_d = SEQ_IDLE;
                else if (instr_last) state_d = SEQ_TAKE;
            end
            SEQ_TAKE: if (ack)       state_d = SEQ_IDLE;
            default:                 state_d = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign wait_set = cpu_wait && (state_q != SEQ_TAKE) && (state_d == SEQ_TAKE);
    assign req      = (state_q == SEQ_TAKE);
endmodule

// File: rtl/brk_unit.sv
// Module: address-match breakpoint unit (top).
// Ties register file, comparator and sequencer together and drives the CPU-facing outputs.
module brk_unit
    import brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              instr_last_i,
    input  logic              monitor_i,
    input  logic              cpu_wait_i,
    input  logic              brk_ack_i,
    output logic              brk_req_o,
    output logic              force_op_o,
    output logic [BYTE_W-1:0] opcode_o,
    output logic [ADDR_W-1:0] vector_o
);
    logic [ADDR_W-1:0] target_w;
    logic              en_w, hit_w, hit_event_w, wait_set_w, req_w;

    brk_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hit_event (hit_event_w),
        .wait_set  (wait_set_w),
        .target    (target_w),
        .en        (en_w)
    );

    brk_match u_match (
        .bus_addr (cpu_addr_i),
        .target   (target_w),
        .en       (en_w),
        .hit      (hit_w)
    );

    brk_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_w),
        .hit        (hit_w),
        .instr_last (instr_last_i),
        .ack        (brk_ack_i),
        .cpu_wait   (cpu_wait_i),
        .hit_event  (hit_event_w),
        .wait_set   (wait_set_w),
        .req        (req_w)
    );

    // CPU-facing outputs: request, forced opcode and mode-selected vector.
    always_comb begin
        brk_req_o  = req_w;
        force_op_o = req_w;
        opcode_o   = req_w ? SWI_OP : '0;
        vector_o   = monitor_i ? VEC_MON : VEC_USER;
    end
endmodule

// File: rtl/brk_unit_chk.sv
// Module: assertion checker bound to brk_unit.
module brk_unit_chk
    import brk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_rdata,
    input logic              instr_last_i,
    input logic              brk_ack_i,
    input logic              brk_req_o,
    input logic              en,
    input logic              flag
);
    AST_REQ_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_req_o) |-> $past(instr_last_i));                       // R6
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_req_o) |-> $past(en));                                 // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req_o && !brk_ack_i) |=> brk_req_o);                        // R9
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req_o && brk_ack_i) |=> !brk_req_o);                        // R9
    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !flag);                                                  // R5
    AST_AUX_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_AUX) |-> (reg_rdata[7:1] == 7'd0));             // R3
endmodule

bind brk_unit brk_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .instr_last_i (instr_last_i),
    .brk_ack_i    (brk_ack_i),
    .brk_req_o    (brk_req_o),
    .en           (en_w),
    .flag         (u_regs.flag_q)
);

// File: tb/brk_unit_tb.sv
`timescale 1ns/1ps
module brk_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] cpu_addr_i = '0;
    logic        instr_last_i = 1'b0;
    logic        monitor_i = 1'b0;
    logic        cpu_wait_i = 1'b0;
    logic        brk_ack_i = 1'b0;
    logic        brk_req_o, force_op_o;
    logic [7:0]  opcode_o;
    logic [15:0] vector_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        bit          is_rd;
        logic [7:0]  rd;
        logic        req;
        logic [15:0] vec;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    brk_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr_i(cpu_addr_i),
        .instr_last_i(instr_last_i), .monitor_i(monitor_i), .cpu_wait_i(cpu_wait_i),
        .brk_ack_i(brk_ack_i), .brk_req_o(brk_req_o), .force_op_o(force_op_o),
        .opcode_o(opcode_o), .vector_o(vector_o)
    );

    // Monitor: pop every queued expectation at the falling edge and compare.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (it.is_rd) begin
                if (reg_rdata !== it.rd) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h expected %h", it.tag, reg_rdata, it.rd);
                end
            end else begin
                logic [7:0] exp_op;
                exp_op = it.req ? 8'h83 : 8'h00;
                if (brk_req_o !== it.req || force_op_o !== it.req || opcode_o !== exp_op ||
                    (it.req && vector_o !== it.vec)) begin
                    n_fail++;
                    $display("FAIL %s: req=%b force=%b op=%h vec=%h expected req=%b op=%h vec=%h",
                             it.tag, brk_req_o, force_op_o, opcode_o, vector_o,
                             it.req, exp_op, it.vec);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic exp_rd(input string tag, input logic [15:0] a, input logic [7:0] d);
        item_t it;
        reg_addr = a;
        it.tag = tag; it.is_rd = 1; it.rd = d; it.req = 0; it.vec = '0;
        sb_q.push_back(it);
        settle();
    endtask

    task automatic exp_out(input string tag, input logic r, input logic [15:0] v);
        item_t it;
        it.tag = tag; it.is_rd = 0; it.rd = '0; it.req = r; it.vec = v;
        sb_q.push_back(it);
        settle();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    // Driver: stimulus and expected values from the requirements.
    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset values
        exp_out("R1 no request after reset", 1'b0, 16'hFFFC);
        exp_rd("R1 status reset", 16'hFE00, 8'h10);
        exp_rd("R1 control reset", 16'hFE0B, 8'h00);
        exp_rd("R1 target high reset", 16'hFE09, 8'h00);
        exp_rd("R1 target low reset", 16'hFE0A, 8'h00);
        exp_rd("R1 aux reset", 16'hFE02, 8'h00);
        exp_rd("R1 flag-control reset", 16'hFE03, 8'h00);

        // R2 target registers
        wr(16'hFE09, 8'h12);
        wr(16'hFE0A, 8'h34);
        exp_rd("R2 target high", 16'hFE09, 8'h12);
        exp_rd("R2 target low", 16'hFE0A, 8'h34);

        // R3 unimplemented bits
        wr(16'hFE02, 8'hFF);
        wr(16'hFE03, 8'hFF);
        wr(16'hFE05, 8'hFF);
        exp_rd("R3 aux only bit0", 16'hFE02, 8'h01);
        exp_rd("R3 flag-control only bit7", 16'hFE03, 8'h80);
        exp_rd("R3 unmapped offset", 16'hFE05, 8'h00);
        wr(16'hFE02, 8'hFE);
        exp_rd("R3 aux bit0 cleared", 16'hFE02, 8'h00);

        // R4 disabled unit ignores a match
        cpu_addr_i = 16'h1234; instr_last_i = 1'b1;
        tick();
        exp_out("R4 disabled no request", 1'b0, 16'hFFFC);
        tick();
        exp_out("R4 disabled still no request", 1'b0, 16'hFFFC);
        cpu_addr_i = 16'h0000; instr_last_i = 1'b0;
        exp_rd("R4 disabled no flag", 16'hFE0B, 8'h00);

        // R4 one byte mismatch
        wr(16'hFE0B, 8'h80);
        cpu_addr_i = 16'h1235; instr_last_i = 1'b1;
        tick();
        exp_out("R4 low byte mismatch", 1'b0, 16'hFFFC);
        cpu_addr_i = 16'h1334;
        tick();
        exp_out("R4 high byte mismatch", 1'b0, 16'hFFFC);
        cpu_addr_i = 16'h0000; instr_last_i = 1'b0;
        exp_rd("R4 mismatch no flag", 16'hFE0B, 8'h80);

        // R6 match on a middle cycle is deferred
        tick();
        cpu_addr_i = 16'h1234; instr_last_i = 1'b0;
        tick();
        exp_out("R6 pending, no request yet", 1'b0, 16'hFFFC);
        cpu_addr_i = 16'h0100;
        tick();
        exp_out("R6 still pending", 1'b0, 16'hFFFC);
        instr_last_i = 1'b1;
        tick();
        instr_last_i = 1'b0;
        exp_out("R6 request after boundary", 1'b1, 16'hFFFC);
        exp_rd("R5 flag set by match", 16'hFE0B, 8'hC0);
        brk_ack_i = 1'b1;
        tick();
        brk_ack_i = 1'b0;
        exp_out("R9 request dropped after ack", 1'b0, 16'hFFFC);

        // R5 flag clear rules
        wr(16'hFE0B, 8'hC0);
        exp_rd("R5 write 1 leaves flag", 16'hFE0B, 8'hC0);
        wr(16'hFE0B, 8'h80);
        exp_rd("R5 write 0 clears flag", 16'hFE0B, 8'h80);

        // R7 match on the final cycle, R9 held match, R10 wait bit
        cpu_wait_i = 1'b1;
        cpu_addr_i = 16'h1234; instr_last_i = 1'b1;
        tick();
        cpu_wait_i = 1'b0;
        exp_out("R7 request at once", 1'b1, 16'hFFFC);
        tick();
        exp_out("R9 held without ack", 1'b1, 16'hFFFC);
        brk_ack_i = 1'b1;
        tick();
        brk_ack_i = 1'b0;
        exp_out("R9 dropped after ack", 1'b0, 16'hFFFC);
        tick();
        exp_out("R9 no retrigger on held match", 1'b0, 16'hFFFC);
        tick();
        exp_out("R9 still no retrigger", 1'b0, 16'hFFFC);
        cpu_addr_i = 16'h0000; instr_last_i = 1'b0;
        exp_rd("R10 wait bit set", 16'hFE00, 8'h12);
        wr(16'hFE00, 8'hFF);
        exp_rd("R10 write 1 keeps wait bit", 16'hFE00, 8'h12);
        wr(16'hFE00, 8'h00);
        exp_rd("R10 write 0 clears wait bit", 16'hFE00, 8'h10);

        // R8 monitor-mode vector
        monitor_i = 1'b1;
        cpu_addr_i = 16'h1234; instr_last_i = 1'b1;
        tick();
        cpu_addr_i = 16'h0000; instr_last_i = 1'b0;
        exp_out("R8 monitor vector", 1'b1, 16'hFEFC);
        brk_ack_i = 1'b1;
        tick();
        brk_ack_i = 1'b0;
        monitor_i = 1'b0;
        exp_out("R8 released", 1'b0, 16'hFFFC);

        // R5 clearing enable clears flag
        wr(16'hFE0B, 8'h40);
        exp_rd("R5 disable clears flag", 16'hFE0B, 8'h00);

        tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule